// File: doc/BRIEF.md
# Burst-of-Two Dual-Port Synchronous SRAM Model

This block is a synthesizable behavioural model of a synchronous SRAM with a read data port and a separate write data port. Both ports share one address bus, which carries the read address in one half of the memory clock period and the write address in the other half. Every address holds two words, and each access moves both of them on consecutive half-periods. The words are 18 or 36 bits wide, split into 9-bit bytes, and each byte of a written word has its own active-low write select.

The model runs on one fast clock. Each fast cycle is one half of the memory clock period. An internal phase flag, `k_phase_o`, is high during a cycle that ends on a rising K edge and low during a cycle that ends on a rising K# edge. Read data leaves on the same K and K# edges, which is the single-clock arrangement.

A write is held in a buffer until its address and both words are known. It is committed to the array on the next K edge. A read whose address matches the buffered write gets the buffered data, with its byte masks already applied, and not the stale array contents. A separate output-enable flag shows when the read data bus is driven.

Top module: `qdr_b2_sram`

## Requirements
- R1: After reset `k_phase_o` is 1 in the first cycle and then inverts on every clock edge. A cycle with `k_phase_o`=1 ends on a K edge, and a cycle with `k_phase_o`=0 ends on a K# edge.
- R2: `rd_sel_ni` low at a K edge starts a read and captures `addr_i` at that edge. Word 0 of that address is on `rdata_o` after the next K edge, which is two fast edges later. Word 1 follows after the K# edge after that.
- R3: `wr_sel_ni` low at a K edge starts a write. `wdata_i` and `bw_ni` at that edge form word 0. `addr_i`, `wdata_i` and `bw_ni` at the following K# edge form the write address and word 1. A read issued at the next K edge or later returns the written data.
- R4: Each address stores two independent words. Word 0 sits at the word-0 position of a burst and word 1 at the word-1 position, with no other burst length.
- R5: For each data word, bit b of `bw_ni` low writes byte b (bits 9b+8 down to 9b) of that word. A high bit leaves that byte's stored value unchanged.
- R6: `rdata_oe_o` is high in exactly the two cycles that carry a read burst and low otherwise. It drops one cycle after the last word when no further read follows. `rdata_o` is zero whenever `rdata_oe_o` is low.
- R7: A read issued at the same K edge as a write to the same address returns the new words, merged byte by byte with the prior contents under the write's masks.
- R8: A read and a write to different addresses, both issued at the same K edge, each complete correctly.
- R9: Reads issued at consecutive K edges produce an unbroken stream of words, with `rdata_oe_o` held high.
- R10: With a port select high, `addr_i`, `wdata_i` and `bw_ni` have no effect on the stored contents or on the read stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock; each cycle is half of the K period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_sel_ni | input | 1 | Read port select, active low, sampled at K edges |
| wr_sel_ni | input | 1 | Write port select, active low, sampled at K edges |
| addr_i | input | ADDR_W | Shared address: read address at K, write address at K# |
| wdata_i | input | WORD_W | Write data, one word per edge |
| bw_ni | input | WORD_W/9 | Byte write selects for the word on `wdata_i`, active low |
| rdata_o | output | WORD_W | Read data, one word per edge |
| rdata_oe_o | output | 1 | High while the read data bus is driven |
| k_phase_o | output | 1 | High when the cycle ends on a K edge |

## Verification
A read and a write can both be issued at the same K edge. When they target the same address, the read's output comes from the write buffer and not from the array. The bench provokes this by issuing a masked write and a read of one address in a single K cycle, over data that was stored earlier. It then requires each returned word to equal the old word with only the selected bytes replaced. A concurrent pair to different addresses, and a read issued right after a write commits, check that forwarding fires only on a matching address and that the committed array agrees with it.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int BYTE_W = 9;
  typedef enum logic {PH_KN = 1'b0, PH_K = 1'b1} phase_e;
endpackage

// File: rtl/qdr_byte_merge.sv
module qdr_byte_merge #(
  parameter int WORD_W = 36
) (
  input  logic [WORD_W-1:0]                 old_i,
  input  logic [WORD_W-1:0]                 new_i,
  input  logic [WORD_W/qdr_pkg::BYTE_W-1:0] be_ni,
  output logic [WORD_W-1:0]                 out_o
);
  localparam int NB = WORD_W / qdr_pkg::BYTE_W;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign out_o[g*qdr_pkg::BYTE_W +: qdr_pkg::BYTE_W] =
      be_ni[g] ? old_i[g*qdr_pkg::BYTE_W +: qdr_pkg::BYTE_W]
               : new_i[g*qdr_pkg::BYTE_W +: qdr_pkg::BYTE_W];
  end
endmodule

// File: rtl/qdr_wr_buf.sv
module qdr_wr_buf #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 36,
  localparam int NB = WORD_W / qdr_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              k_edge_i,
  input  logic              wr_sel_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [NB-1:0]     bw_ni,
  output logic              buf_vld_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [WORD_W-1:0] buf_d0_o,
  output logic [WORD_W-1:0] buf_d1_o,
  output logic [NB-1:0]     buf_be0_o,
  output logic [NB-1:0]     buf_be1_o
);
  logic              half_q;
  logic [WORD_W-1:0] st_d0_q;
  logic [NB-1:0]     st_be0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q     <= 1'b0;
      st_d0_q    <= '0;
      st_be0_q   <= '1;
      buf_vld_o  <= 1'b0;
      buf_addr_o <= '0;
      buf_d0_o   <= '0;
      buf_d1_o   <= '0;
      buf_be0_o  <= '1;
      buf_be1_o  <= '1;
    end else if (k_edge_i) begin
      // complete buffer is committed by the array on this edge
      buf_vld_o <= 1'b0;
      half_q    <= ~wr_sel_ni;
      if (!wr_sel_ni) begin
        st_d0_q  <= wdata_i;
        st_be0_q <= bw_ni;
      end
    end else begin
      if (half_q) begin
        buf_vld_o  <= 1'b1;
        buf_addr_o <= addr_i;
        buf_d0_o   <= st_d0_q;
        buf_be0_o  <= st_be0_q;
        buf_d1_o   <= wdata_i;
        buf_be1_o  <= bw_ni;
      end
      half_q <= 1'b0;
    end
  end

  a_r3_addr_at_kn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_q && !k_edge_i) |=> buf_vld_o);
  a_r3_commit_at_k: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_vld_o && k_edge_i) |=> !buf_vld_o);
endmodule

// File: rtl/qdr_array.sv
module qdr_array #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 36,
  localparam int NB    = WORD_W / qdr_pkg::BYTE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              buf_vld_i,
  input  logic [ADDR_W-1:0] buf_addr_i,
  input  logic [WORD_W-1:0] buf_d0_i,
  input  logic [WORD_W-1:0] buf_d1_i,
  input  logic [NB-1:0]     buf_be0_i,
  input  logic [NB-1:0]     buf_be1_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_d0_o,
  output logic [WORD_W-1:0] rd_d1_o
);
  logic [2*WORD_W-1:0] mem [DEPTH];
  logic [2*WORD_W-1:0] cur, raw;
  logic [WORD_W-1:0]   mrg0, mrg1;
  logic                hit;

  assign cur = mem[buf_addr_i];
  assign raw = mem[rd_addr_i];

  qdr_byte_merge #(.WORD_W(WORD_W)) u_mrg0 (
    .old_i(cur[WORD_W-1:0]), .new_i(buf_d0_i), .be_ni(buf_be0_i), .out_o(mrg0));
  qdr_byte_merge #(.WORD_W(WORD_W)) u_mrg1 (
    .old_i(cur[2*WORD_W-1:WORD_W]), .new_i(buf_d1_i), .be_ni(buf_be1_i), .out_o(mrg1));

  // forward pending write to a matching read
  assign hit     = buf_vld_i && (buf_addr_i == rd_addr_i);
  assign rd_d0_o = hit ? mrg0 : raw[WORD_W-1:0];
  assign rd_d1_o = hit ? mrg1 : raw[2*WORD_W-1:WORD_W];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[buf_addr_i] <= {mrg1, mrg0};
  end

  a_r7_we_has_data: assert property (@(posedge clk_i) we_i |-> buf_vld_i);
endmodule

// File: rtl/qdr_rd_pipe.sv
module qdr_rd_pipe #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              k_edge_i,
  input  logic              rd_sel_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] arr_d0_i,
  input  logic [WORD_W-1:0] arr_d1_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              oe_o
);
  logic              pend_q, second_q;
  logic [WORD_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      second_q  <= 1'b0;
      rd_addr_o <= '0;
      hold_q    <= '0;
      rdata_o   <= '0;
      oe_o      <= 1'b0;
    end else if (k_edge_i) begin
      pend_q <= ~rd_sel_ni;
      if (!rd_sel_ni) rd_addr_o <= addr_i;
      if (pend_q) begin
        rdata_o  <= arr_d0_i;
        hold_q   <= arr_d1_i;
        second_q <= 1'b1;
        oe_o     <= 1'b1;
      end else begin
        rdata_o  <= '0;
        second_q <= 1'b0;
        oe_o     <= 1'b0;
      end
    end else begin
      second_q <= 1'b0;
      if (second_q) begin
        rdata_o <= hold_q;
        oe_o    <= 1'b1;
      end else begin
        rdata_o <= '0;
        oe_o    <= 1'b0;
      end
    end
  end

  a_r2_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_edge_i && pend_q) |=> oe_o);
  a_r6_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |=> oe_o);
  a_r6_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (rdata_o == '0));
  a_r6_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_edge_i && !pend_q) |=> !oe_o);
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 36,
  localparam int NB = WORD_W / qdr_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_sel_ni,
  input  logic              wr_sel_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [NB-1:0]     bw_ni,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              k_phase_o
);
  qdr_pkg::phase_e   phase_q;
  logic              k_edge;
  logic              buf_vld;
  logic [ADDR_W-1:0] buf_addr, rd_addr;
  logic [WORD_W-1:0] buf_d0, buf_d1, arr_d0, arr_d1;
  logic [NB-1:0]     buf_be0, buf_be1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= qdr_pkg::PH_K;
    else         phase_q <= (phase_q == qdr_pkg::PH_K) ? qdr_pkg::PH_KN : qdr_pkg::PH_K;
  end

  assign k_edge    = (phase_q == qdr_pkg::PH_K);
  assign k_phase_o = k_edge;

  qdr_wr_buf #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_wr_buf (
    .clk_i, .rst_ni, .k_edge_i(k_edge), .wr_sel_ni, .addr_i, .wdata_i, .bw_ni,
    .buf_vld_o(buf_vld), .buf_addr_o(buf_addr), .buf_d0_o(buf_d0), .buf_d1_o(buf_d1),
    .buf_be0_o(buf_be0), .buf_be1_o(buf_be1));

  qdr_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
    .clk_i, .we_i(buf_vld && k_edge), .buf_vld_i(buf_vld), .buf_addr_i(buf_addr),
    .buf_d0_i(buf_d0), .buf_d1_i(buf_d1), .buf_be0_i(buf_be0), .buf_be1_i(buf_be1),
    .rd_addr_i(rd_addr), .rd_d0_o(arr_d0), .rd_d1_o(arr_d1));

  qdr_rd_pipe #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rd_pipe (
    .clk_i, .rst_ni, .k_edge_i(k_edge), .rd_sel_ni, .addr_i,
    .arr_d0_i(arr_d0), .arr_d1_i(arr_d1), .rd_addr_o(rd_addr),
    .rdata_o, .oe_o(rdata_oe_o));

  a_r1_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_phase_o |=> !k_phase_o);
  a_r1_alternate_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !k_phase_o |=> k_phase_o);
endmodule

// File: tb/tb_qdr_b2_sram.sv
module tb_qdr_b2_sram;
  localparam int ADDR_W = 4;
  localparam int WORD_W = 36;
  localparam int NB     = WORD_W / 9;

  typedef struct {
    int                due;
    logic [WORD_W-1:0] d;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [WORD_W-1:0] wdata = '0;
  logic [NB-1:0]     bw_n = '1;
  logic [WORD_W-1:0] rdata;
  logic              oe, kph;

  int   n_chk = 0, n_bad = 0, edge_cnt = 0;
  bit   mon_on = 1'b0;
  exp_t q[$];
  logic [2*WORD_W-1:0] model [1<<ADDR_W];

  always #4 clk = ~clk;

  qdr_b2_sram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_sel_ni(rd_sel_n), .wr_sel_ni(wr_sel_n),
    .addr_i(addr), .wdata_i(wdata), .bw_ni(bw_n),
    .rdata_o(rdata), .rdata_oe_o(oe), .k_phase_o(kph));

  always @(posedge clk) if (rst_n) edge_cnt <= edge_cnt + 1;

  task automatic check(bit ok, string tag, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s edge %0d: actual %h expected %h", tag, edge_cnt, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] merge(logic [WORD_W-1:0] o, logic [WORD_W-1:0] n,
                                              logic [NB-1:0] m);
    logic [WORD_W-1:0] r = o;
    for (int b = 0; b < NB; b++) if (!m[b]) r[b*9 +: 9] = n[b*9 +: 9];
    return r;
  endfunction

  // monitor: compare against queued expectations; idle bus otherwise
  always @(negedge clk) begin
    if (mon_on) begin
      check(kph == ((edge_cnt % 2) == 0), "R1 phase", {35'd0, kph},
            {35'd0, ((edge_cnt % 2) == 0)});
      if (q.size() > 0 && q[0].due == edge_cnt) begin
        check(oe === 1'b1, {q[0].tag, " oe"}, {35'd0, oe}, 36'd1);
        check(rdata === q[0].d, q[0].tag, rdata, q[0].d);
        void'(q.pop_front());
      end else begin
        check(oe === 1'b0 && rdata === '0, "R6 idle bus", rdata, '0);
      end
    end
  end

  // one K period: read/write select at K, write address/word1 at K#
  task automatic kcyc(bit rd, logic [ADDR_W-1:0] ra, bit wr, logic [ADDR_W-1:0] wa,
                      logic [WORD_W-1:0] w0, logic [NB-1:0] m0,
                      logic [WORD_W-1:0] w1, logic [NB-1:0] m1, string tag);
    int e0;
    exp_t x;
    @(negedge clk);
    while (!kph) @(negedge clk);
    e0 = edge_cnt + 1;
    if (wr) model[wa] = {merge(model[wa][2*WORD_W-1:WORD_W], w1, m1),
                         merge(model[wa][WORD_W-1:0], w0, m0)};
    if (rd) begin
      x.due = e0 + 2; x.d = model[ra][WORD_W-1:0];        x.tag = {tag, " w0"}; q.push_back(x);
      x.due = e0 + 3; x.d = model[ra][2*WORD_W-1:WORD_W]; x.tag = {tag, " w1"}; q.push_back(x);
    end
    rd_sel_n = !rd; wr_sel_n = !wr; addr = ra; wdata = w0; bw_n = m0;
    @(negedge clk);
    rd_sel_n = 1'b1; wr_sel_n = 1'b1; addr = wa; wdata = w1; bw_n = m1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) kcyc(0, 4'hF, 0, 4'hE, 36'hBAD_BAD_BAD, '0, 36'hDEAD_DEAD_D, '0, "idle");
  endtask

  initial begin
    fork
      begin
        #20;
        @(negedge clk);
        check(oe === 1'b0 && rdata === '0, "R6 reset bus", rdata, '0);
        check(kph === 1'b1, "R1 reset phase", {35'd0, kph}, 36'd1);
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(2);
        // R3 R4: full-mask writes of distinct word pairs
        for (int a = 0; a < 8; a++)
          kcyc(0, 0, 1, a[ADDR_W-1:0], 36'h100000000 + a, '0, 36'h2000000F0 + a, '0, "R3");
        idle(1);
        // R2 R4: read them back with gaps
        for (int a = 0; a < 8; a++) begin
          kcyc(1, a[ADDR_W-1:0], 0, 0, '0, '1, '0, '1, "R2 R4 readback");
          idle(1);
        end
        // R5: byte-masked write, different masks per word
        kcyc(0, 0, 1, 4'd2, 36'hAAAAAAAAA, 4'b1010, 36'h555555555, 4'b0110, "R5");
        idle(1);
        kcyc(1, 4'd2, 0, 0, '0, '1, '0, '1, "R5 masked read");
        idle(1);
        // R10: selects high, junk on address/data/masks
        kcyc(0, 4'd3, 0, 4'd3, 36'hFFFFFFFFF, '0, 36'hFFFFFFFFF, '0, "R10");
        kcyc(1, 4'd3, 0, 0, '0, '1, '0, '1, "R10 unchanged");
        idle(1);
        // R7: read and masked write of one address at the same K edge
        kcyc(1, 4'd5, 1, 4'd5, 36'h123456789, 4'b0101, 36'h987654321, 4'b1001, "R7 forward");
        idle(1);
        kcyc(1, 4'd5, 0, 0, '0, '1, '0, '1, "R7 committed");
        idle(1);
        // R8: concurrent read and write, different addresses
        kcyc(1, 4'd1, 1, 4'd9, 36'h0F0F0F0F0, '0, 36'hF0F0F0F0F, '0, "R8 concurrent");
        kcyc(1, 4'd9, 0, 0, '0, '1, '0, '1, "R8 new addr");
        idle(1);
        // R3: write then read at the very next K edge
        kcyc(0, 0, 1, 4'd7, 36'h777777777, 4'b0000, 36'h666666666, 4'b1110, "R3");
        kcyc(1, 4'd7, 0, 0, '0, '1, '0, '1, "R3 next read");
        idle(1);
        // R9: back-to-back reads mixed with writes
        kcyc(1, 4'd0, 1, 4'd10, 36'hCAFECAFE0, '0, 36'hBEEFBEEF1, '0, "R9 stream");
        kcyc(1, 4'd10, 1, 4'd10, 36'h000000011, 4'b1110, 36'h000000022, 4'b0111, "R9 stream");
        kcyc(1, 4'd10, 0, 0, '0, '1, '0, '1, "R9 stream");
        kcyc(1, 4'd4, 0, 0, '0, '1, '0, '1, "R9 stream");
        idle(4);
        check(q.size() == 0, "R6 drained", q.size(), 0);
      end
      begin
        #(200000 * 8);
        check(1'b0, "watchdog", '0, '1);
      end
    join_any
    disable fork;
    mon_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule